// File: doc/BRIEF.md
# Doppler Elastic Bit Buffer

This block is a bit-serial elastic store that sits between a receive clock recovered from the link and a smoothed output clock. Both sides are presented as enable strobes in one system clock: each write strobe stores one data bit, and each read strobe returns the oldest stored bit. The buffer absorbs the slow drift between the two rates, so the output side sees a steady stream while the input rate moves with Doppler and oscillator offset.

The usable depth is chosen at run time as a power of two between 512 and 32768 bits. The buffer re-centres itself whenever its position becomes meaningless: after reset, when the receiver first gains lock, when the selected depth changes, on a manual request, and whenever it slips by running full or empty. Centring puts the fill level at half the selected depth in a single cycle. The bits between the new read position and the write position are old data, so they are replaced by a fixed fill bit on the output. Each slip is counted and latched in a sticky flag, so the size and sign of the clock offset can be worked out from how often each kind of slip occurs.

Top module: `doppler_elastic_buf`

## Requirements
- R1: The depth select code k (0 to 6) selects a depth of 512·2^k bits, and code 7 acts as code 6. The fill level never exceeds the selected depth.
- R2: After reset the fill level, both flags and both counters read 0 and the read bit reads 1. In the first cycle after reset release the buffer centres, so the fill level becomes half the selected depth. The first half-depth reads then return the fill bit 1.
- R3: Outside centring cycles, bits come out in the order they were written, once the fill-bit region has been read. The fill level rises by one for an accepted write and falls by one for an accepted read. The read bit appears on the output one cycle after its strobe.
- R4: A rising edge on the lock input centres the buffer. While lock stays high, no further centring comes from it.
- R5: A manual centre request centres the buffer in the cycle it is sampled.
- R6: A change of the effective depth code centres the buffer at half the new depth.
- R7: A write without a read, when the fill level is one below the depth, is an overflow. The overflow is counted, its sticky flag is set, the buffer centres, and the written bit is dropped.
- R8: A read at fill level 0 is an underflow. The underflow is counted, its sticky flag is set, the buffer centres, and the read returns the fill bit.
- R9: Each slip counter saturates at its all-ones value. A counter never decreases except when cleared.
- R10: A fault clear zeroes both flags and both counters. A slip in the same cycle leaves its flag set and its counter at 1.
- R11: A read and a write in the same cycle, with no centring, leave the fill level unchanged.
- R12: In a centring cycle, a write is dropped and a read returns the fill bit without consuming data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one bit per strobe |
| wr_bit | input | 1 | Data bit written on the strobe |
| rd_en | input | 1 | Read strobe |
| rd_bit | output | 1 | Bit returned by the last read strobe |
| depth_sel | input | SEL_W (3) | Depth code, depth = 512·2^code, with saturation at code 6 |
| rx_lock | input | 1 | Receiver lock state; its rising edge centres the buffer |
| centre_req | input | 1 | Manual centre request |
| fault_clr | input | 1 | Clears the slip flags and counters |
| fill_lvl | output | FILL_W (16) | Bits held, including the fill-bit region |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |
| ovf_cnt | output | CNT_W (16) | Saturating overflow count |
| udf_cnt | output | CNT_W (16) | Saturating underflow count |

## Verification
Every result is registered once. A strobe, a lock edge, a centre request, a depth change or a clear sampled at one rising edge is visible on `fill_lvl`, `rd_bit`, the flags and the counters right after that edge, with no further latency. The bench drives each stimulus after a falling edge and compares the outputs at the next falling edge against a queue model of written bits, a fill-bit count and slip counters kept in the bench. It sweeps strobe patterns, all depth codes, slips at three depths and counter saturation with a 4-bit counter build.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    // Limit a depth code to the largest legal code.
    function automatic int unsigned clamp_code(input int unsigned code, input int unsigned span);
        return (code > span) ? span : code;
    endfunction

    // Reason for a centring event, in priority order.
    typedef enum logic [2:0] {
        CTR_NONE,
        CTR_INIT,
        CTR_SLIP,
        CTR_RESIZE,
        CTR_LOCK,
        CTR_MANUAL
    } ctr_cause_e;

endpackage

// File: rtl/dbuf_depth_dec.sv
module dbuf_depth_dec #(
    parameter int MIN_LOG2 = 9,
    parameter int MAX_LOG2 = 15,
    parameter int SEL_W    = 3,
    parameter int FILL_W   = MAX_LOG2 + 1
) (
    input  logic [SEL_W-1:0]  sel,
    output logic [FILL_W-1:0] depth
);
    localparam int SPAN   = MAX_LOG2 - MIN_LOG2;
    localparam int NCODES = 2 ** SEL_W;

    logic [FILL_W-1:0] depth_tab [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_code
        localparam int LOG2 = MIN_LOG2 + ((g > SPAN) ? SPAN : g);
        assign depth_tab[g] = FILL_W'(1) << LOG2;
    end

    assign depth = depth_tab[sel];
endmodule

// File: rtl/dbuf_bitmem.sv
module dbuf_bitmem #(
    parameter int ADDR_W = 15,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wbit,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rbit
);
    localparam int LANE_W = $clog2(WORD_W);
    localparam int NWORDS = (2 ** ADDR_W) / WORD_W;

    logic [WORD_W-1:0] mem [NWORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr[ADDR_W-1:LANE_W]][waddr[LANE_W-1:0]] <= wbit;
        end
    end

    assign rbit = mem[raddr[ADDR_W-1:LANE_W]][raddr[LANE_W-1:0]];
endmodule

// File: rtl/dbuf_ctrl.sv
module dbuf_ctrl
    import dbuf_pkg::*;
#(
    parameter int   MIN_LOG2 = 9,
    parameter int   MAX_LOG2 = 15,
    parameter int   SEL_W    = 3,
    parameter int   CNT_W    = 16,
    parameter logic FILL_BIT = 1'b1,
    parameter int   PTR_W    = MAX_LOG2,
    parameter int   FILL_W   = MAX_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              rx_lock,
    input  logic              centre_req,
    input  logic              fault_clr,
    input  logic [SEL_W-1:0]  depth_sel,
    input  logic [FILL_W-1:0] depth_new,
    input  logic [FILL_W-1:0] depth_cur,
    input  logic              mem_rbit,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_waddr,
    output logic [PTR_W-1:0]  mem_raddr,
    output logic [SEL_W-1:0]  sel_cur,
    output logic              ctr_evt,
    output logic              rd_bit,
    output logic [FILL_W-1:0] fill_lvl,
    output logic              ovf_flag,
    output logic              udf_flag,
    output logic [CNT_W-1:0]  ovf_cnt,
    output logic [CNT_W-1:0]  udf_cnt
);
    localparam int SPAN = MAX_LOG2 - MIN_LOG2;

    typedef struct packed {
        logic [PTR_W-1:0]  wptr;
        logic [PTR_W-1:0]  rptr;
        logic [FILL_W-1:0] fill;
        logic [FILL_W-1:0] stale;
        logic [SEL_W-1:0]  sel;
        logic              lock;
        logic              pend;
        logic              rdat;
        logic              ovf;
        logic              udf;
        logic [CNT_W-1:0]  ovf_cnt;
        logic [CNT_W-1:0]  udf_cnt;
    } state_t;

    state_t     st_d, st_q;
    ctr_cause_e cause;

    logic [SEL_W-1:0]  sel_new;
    logic [FILL_W-1:0] half_new;
    logic [PTR_W-1:0]  addr_mask;
    logic              ovf_hit, udf_hit;

    always_comb begin
        sel_new   = SEL_W'(clamp_code(int'(depth_sel), SPAN));
        half_new  = depth_new >> 1;
        addr_mask = PTR_W'(depth_cur - FILL_W'(1));

        ovf_hit = !st_q.pend && wr_en && !rd_en && (st_q.fill == depth_cur - FILL_W'(1));
        udf_hit = !st_q.pend && rd_en && (st_q.fill == '0);

        if (st_q.pend)                     cause = CTR_INIT;
        else if (ovf_hit || udf_hit)       cause = CTR_SLIP;
        else if (sel_new != st_q.sel)      cause = CTR_RESIZE;
        else if (rx_lock && !st_q.lock)    cause = CTR_LOCK;
        else if (centre_req)               cause = CTR_MANUAL;
        else                               cause = CTR_NONE;

        st_d      = st_q;
        st_d.pend = 1'b0;
        st_d.lock = rx_lock;
        st_d.sel  = sel_new;

        if (cause != CTR_NONE) begin
            st_d.rptr  = st_q.wptr - PTR_W'(half_new);
            st_d.fill  = half_new;
            st_d.stale = half_new;
            if (rd_en) begin
                st_d.rdat = FILL_BIT;
            end
        end else begin
            if (wr_en) begin
                st_d.wptr = st_q.wptr + PTR_W'(1);
            end
            if (rd_en) begin
                st_d.rptr = st_q.rptr + PTR_W'(1);
                if (st_q.stale != '0) begin
                    st_d.rdat  = FILL_BIT;
                    st_d.stale = st_q.stale - FILL_W'(1);
                end else begin
                    st_d.rdat = mem_rbit;
                end
            end
            st_d.fill = st_q.fill + FILL_W'(wr_en) - FILL_W'(rd_en);
        end

        if (fault_clr) begin
            st_d.ovf     = 1'b0;
            st_d.udf     = 1'b0;
            st_d.ovf_cnt = '0;
            st_d.udf_cnt = '0;
        end
        if (ovf_hit) begin
            st_d.ovf = 1'b1;
            if (st_d.ovf_cnt != {CNT_W{1'b1}}) begin
                st_d.ovf_cnt = st_d.ovf_cnt + CNT_W'(1);
            end
        end
        if (udf_hit) begin
            st_d.udf = 1'b1;
            if (st_d.udf_cnt != {CNT_W{1'b1}}) begin
                st_d.udf_cnt = st_d.udf_cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.pend <= 1'b1;
            st_q.rdat <= FILL_BIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctr_evt   = (cause != CTR_NONE);
    assign mem_we    = wr_en && !ctr_evt;
    assign mem_waddr = st_q.wptr & addr_mask;
    assign mem_raddr = st_q.rptr & addr_mask;
    assign sel_cur   = st_q.sel;
    assign rd_bit    = st_q.rdat;
    assign fill_lvl  = st_q.fill;
    assign ovf_flag  = st_q.ovf;
    assign udf_flag  = st_q.udf;
    assign ovf_cnt   = st_q.ovf_cnt;
    assign udf_cnt   = st_q.udf_cnt;
endmodule

// File: rtl/doppler_elastic_buf.sv
module doppler_elastic_buf #(
    parameter int   MIN_LOG2 = 9,
    parameter int   MAX_LOG2 = 15,
    parameter int   CNT_W    = 16,
    parameter logic FILL_BIT = 1'b1,
    localparam int  SEL_W    = $clog2(MAX_LOG2 - MIN_LOG2 + 1),
    localparam int  FILL_W   = MAX_LOG2 + 1,
    localparam int  PTR_W    = MAX_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bit,
    input  logic              rd_en,
    output logic              rd_bit,
    input  logic [SEL_W-1:0]  depth_sel,
    input  logic              rx_lock,
    input  logic              centre_req,
    input  logic              fault_clr,
    output logic [FILL_W-1:0] fill_lvl,
    output logic              ovf_flag,
    output logic              udf_flag,
    output logic [CNT_W-1:0]  ovf_cnt,
    output logic [CNT_W-1:0]  udf_cnt
);
    logic [SEL_W-1:0]  sel_cur;
    logic [FILL_W-1:0] depth_new, depth_cur;
    logic              ctr_evt;
    logic              mem_we, mem_rbit;
    logic [PTR_W-1:0]  mem_waddr, mem_raddr;

    dbuf_depth_dec #(
        .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2), .SEL_W(SEL_W), .FILL_W(FILL_W)
    ) i_dec_new (
        .sel   (depth_sel),
        .depth (depth_new)
    );

    dbuf_depth_dec #(
        .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2), .SEL_W(SEL_W), .FILL_W(FILL_W)
    ) i_dec_cur (
        .sel   (sel_cur),
        .depth (depth_cur)
    );

    dbuf_bitmem #(
        .ADDR_W(PTR_W), .WORD_W(32)
    ) i_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wbit  (wr_bit),
        .raddr (mem_raddr),
        .rbit  (mem_rbit)
    );

    dbuf_ctrl #(
        .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2), .SEL_W(SEL_W), .CNT_W(CNT_W),
        .FILL_BIT(FILL_BIT), .PTR_W(PTR_W), .FILL_W(FILL_W)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .rx_lock    (rx_lock),
        .centre_req (centre_req),
        .fault_clr  (fault_clr),
        .depth_sel  (depth_sel),
        .depth_new  (depth_new),
        .depth_cur  (depth_cur),
        .mem_rbit   (mem_rbit),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_raddr  (mem_raddr),
        .sel_cur    (sel_cur),
        .ctr_evt    (ctr_evt),
        .rd_bit     (rd_bit),
        .fill_lvl   (fill_lvl),
        .ovf_flag   (ovf_flag),
        .udf_flag   (udf_flag),
        .ovf_cnt    (ovf_cnt),
        .udf_cnt    (udf_cnt)
    );
endmodule

// File: rtl/dbuf_chk.sv
module dbuf_chk #(
    parameter int MIN_LOG2 = 9,
    parameter int MAX_LOG2 = 15,
    parameter int CNT_W    = 16,
    parameter int SEL_W    = 3,
    parameter int FILL_W   = MAX_LOG2 + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              centre_req,
    input logic              fault_clr,
    input logic              ctr_evt,
    input logic [SEL_W-1:0]  sel_cur,
    input logic [FILL_W-1:0] fill_lvl,
    input logic              ovf_flag,
    input logic              udf_flag,
    input logic [CNT_W-1:0]  ovf_cnt,
    input logic [CNT_W-1:0]  udf_cnt
);
    logic [FILL_W-1:0] cur_depth;
    logic              live;

    assign cur_depth = FILL_W'(1) << (MIN_LOG2 + int'(sel_cur));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // R1
    fill_within_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_lvl <= cur_depth);

    // R7
    overflow_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && wr_en && !rd_en && (fill_lvl == cur_depth - FILL_W'(1)) |=> ovf_flag && (ovf_cnt != '0));

    // R8
    underflow_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && rd_en && (fill_lvl == '0) |=> udf_flag && (udf_cnt != '0));

    // R5
    manual_centre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        centre_req |=> fill_lvl == (cur_depth >> 1));

    // R11
    balanced_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && rd_en && !ctr_evt |=> $stable(fill_lvl));

    // R10
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr && !ctr_evt |=> !ovf_flag && !udf_flag && (ovf_cnt == '0) && (udf_cnt == '0));

    // R9
    ovf_count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_clr |=> ovf_cnt >= $past(ovf_cnt));

    // R9
    udf_count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_clr |=> udf_cnt >= $past(udf_cnt));
endmodule

bind doppler_elastic_buf dbuf_chk #(
    .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2), .CNT_W(CNT_W), .SEL_W(SEL_W), .FILL_W(FILL_W)
) i_dbuf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .centre_req (centre_req),
    .fault_clr  (fault_clr),
    .ctr_evt    (ctr_evt),
    .sel_cur    (sel_cur),
    .fill_lvl   (fill_lvl),
    .ovf_flag   (ovf_flag),
    .udf_flag   (udf_flag),
    .ovf_cnt    (ovf_cnt),
    .udf_cnt    (udf_cnt)
);

// File: tb/test_doppler_elastic_buf.sv
module test_doppler_elastic_buf;
    localparam int CW    = 4;
    localparam int CMAX  = 15;
    localparam bit FILLB = 1'b1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 0, wr_bit = 0, rd_en = 0;
    logic        rx_lock = 0, centre_req = 0, fault_clr = 0;
    logic [2:0]  depth_sel = 0;
    logic        rd_bit, ovf_flag, udf_flag;
    logic [15:0] fill_lvl;
    logic [CW-1:0] ovf_cnt, udf_cnt;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model
    bit q[$];
    int m_stale = 0, m_sel = 0, m_ocnt = 0, m_ucnt = 0;
    bit m_pend = 1, m_lock = 0, m_rd = FILLB, m_ovf = 0, m_udf = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    doppler_elastic_buf #(.CNT_W(CW)) i_doppler_elastic_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit), .rd_en(rd_en),
        .rd_bit(rd_bit), .depth_sel(depth_sel), .rx_lock(rx_lock),
        .centre_req(centre_req), .fault_clr(fault_clr), .fill_lvl(fill_lvl),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag), .ovf_cnt(ovf_cnt), .udf_cnt(udf_cnt)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int m_fill();
        return m_stale + q.size();
    endfunction

    function automatic bit next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // one cycle: drive, update model, check after the edge
    task automatic step(input bit we, input bit wb, input bit re, input string tag);
        int  new_sel, dep_cur;
        bit  ovf, udf, ctr, rd_checked;
        wr_en = we; wr_bit = wb; rd_en = re;
        new_sel = (depth_sel > 6) ? 6 : int'(depth_sel);
        dep_cur = 512 << m_sel;
        ovf = !m_pend && we && !re && (m_fill() == dep_cur - 1);
        udf = !m_pend && re && (m_fill() == 0);
        ctr = m_pend || ovf || udf || (new_sel != m_sel) || (rx_lock && !m_lock) || centre_req;
        rd_checked = re;
        if (ctr) begin
            q.delete();
            m_stale = 256 << new_sel;
            if (re) m_rd = FILLB;
        end else begin
            if (re) begin
                if (m_stale > 0) begin m_rd = FILLB; m_stale--; end
                else m_rd = q.pop_front();
            end
            if (we) q.push_back(wb);
        end
        if (fault_clr) begin m_ovf = 0; m_udf = 0; m_ocnt = 0; m_ucnt = 0; end
        if (ovf) begin m_ovf = 1; if (m_ocnt < CMAX) m_ocnt++; end
        if (udf) begin m_udf = 1; if (m_ucnt < CMAX) m_ucnt++; end
        m_pend = 0; m_lock = rx_lock; m_sel = new_sel;
        @(negedge clk);
        chk(tag, "fill_lvl", 32'(fill_lvl), 32'(m_fill()));
        if (rd_checked) chk(tag, "rd_bit", 32'(rd_bit), 32'(m_rd));
        chk(tag, "ovf_flag", 32'(ovf_flag), 32'(m_ovf));
        chk(tag, "udf_flag", 32'(udf_flag), 32'(m_udf));
        chk(tag, "ovf_cnt", 32'(ovf_cnt), 32'(m_ocnt));
        chk(tag, "udf_cnt", 32'(udf_cnt), 32'(m_ucnt));
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        chk("R2", "reset fill", 32'(fill_lvl), 0);
        chk("R2", "reset flags", 32'({ovf_flag, udf_flag}), 0);
        chk("R2", "reset counts", 32'({ovf_cnt, udf_cnt}), 0);
        chk("R2", "reset rd_bit", 32'(rd_bit), 32'(FILLB));
        rst_n = 1'b1;
        idle("R2");
        // R2: fill-bit region drains first
        repeat (256) step(0, 0, 1, "R2");
        // R8: read at empty
        step(0, 0, 1, "R8");

        // R3: mixed strobe sweep (reaches overflow naturally)
        for (int i = 0; i < 3000; i++) step((i % 3) != 0, next_bit(), (i % 2) == 0, "R3");

        // R6 / R1: every depth code, then hold
        for (int s = 0; s < 8; s++) begin
            depth_sel = 3'(s);
            idle("R6");
            step(1, next_bit(), 0, "R1");
        end

        // R7 / R8 at three depths
        for (int s = 0; s < 3; s++) begin
            depth_sel = 3'(s);
            idle("R6");
            repeat (256 << s) step(1, next_bit(), 0, "R7");
            repeat ((256 << s) + 1) step(0, 0, 1, "R8");
        end

        depth_sel = 0;
        idle("R6");
        // R4: lock edge centres, steady lock does not
        repeat (5) step(1, next_bit(), 0, "R4");
        rx_lock = 1;
        step(1, next_bit(), 0, "R4");
        repeat (5) step(1, next_bit(), 0, "R4");
        rx_lock = 0;
        step(1, next_bit(), 0, "R4");
        rx_lock = 1;
        step(0, 0, 0, "R4");

        // R5: manual centre
        repeat (3) step(1, next_bit(), 0, "R5");
        centre_req = 1;
        step(0, 0, 0, "R5");
        centre_req = 0;

        // R12: access during centring
        repeat (4) step(1, 0, 0, "R12");
        repeat (257) step(0, 0, 1, "R12");
        centre_req = 1;
        step(1, 0, 1, "R12");
        centre_req = 0;
        idle("R12");

        // R11: balanced read and write
        for (int i = 0; i < 300; i++) step(1, next_bit(), 1, "R11");

        // R9: underflow counter saturation
        for (int k = 0; k < 17; k++) begin
            while (m_fill() > 0) step(0, 0, 1, "R9");
            step(0, 0, 1, "R9");
        end
        chk("R9", "saturated udf_cnt", 32'(udf_cnt), CMAX);

        // R10: clear alone, then clear with a slip
        fault_clr = 1;
        idle("R10");
        fault_clr = 0;
        while (m_fill() > 0) step(0, 0, 1, "R10");
        fault_clr = 1;
        step(0, 0, 1, "R10");
        fault_clr = 0;
        chk("R10", "udf_cnt after clear with slip", 32'(udf_cnt), 1);
        idle("R10");

        finish_run();
    end
endmodule